// File: doc/BRIEF.md
# GPIO Bank with Interrupt Logic

A bank of up to 32 general-purpose pins behind a small 32-bit register port. Software drives each pin's output level and output enable, reads back the synchronized pad levels, and picks a trigger condition per pin (rising edge, falling edge, high level or low level). Pins that meet their condition are latched as pending. All pending pins whose interrupt is enabled are ORed into one interrupt line toward a parent controller.

The output level, the interrupt enable and the pending flags are never rewritten as a whole word. The output and the enable each have a set address and a clear address, where a 1 bit acts and a 0 bit leaves the pin alone. Pending flags are cleared by writing ones to the status address. Two mode registers must both mark a pin before it is treated as edge-triggered, so one stray write cannot turn a level pin into an edge pin.

The register port is a request/response stream. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Each accepted request, read or write, gives exactly one response beat on the next cycle. While a response is valid and `rsp_ready` is low, that response and its data stay unchanged and `req_ready` stays low, so no new request can overtake it. Unmapped or misaligned addresses read as zero, and writes to them have no effect.

Top module: `gpio_irq_bank`

## Requirements
- R1: Reading the level register (offset 0x00) returns the pad inputs after a two-flop synchronizer, bit n for pin n.
- R2: A write to offset 0x08 drives high every pin whose data bit is 1. A write to offset 0x0C drives low every pin whose data bit is 1. Zero bits leave pins unchanged. Offset 0x04 reads back the output state, which is also presented on `pad_out`.
- R3: The direction register at offset 0x10 is read/write. A 1 makes the pin drive, and `pad_oe` equals this register.
- R4: The interrupt enable reads at offset 0x14 and is changed only by writing ones to offset 0x18 (set) or offset 0x1C (clear). A write to offset 0x14 has no effect.
- R5: The pending register at offset 0x20 clears each bit written as 1. Bits written as 0 stay pending.
- R6: A pin with its bit set in both mode registers (offsets 0x24 and 0x28) is edge-triggered. The polarity register (offset 0x2C) picks a rising edge when the bit is 1 and a falling edge when it is 0. A level held after the edge does not set the pin pending again.
- R7: A pin that is not edge-triggered is level-triggered and becomes pending while its level equals its polarity bit. An acknowledge clears it for one cycle, and it becomes pending again on the next cycle if the level is still active.
- R8: Pins become pending whether or not their interrupt is enabled. `irq` is high exactly when some pin is both pending and enabled.
- R9: If an edge event and an acknowledge hit the same edge-triggered pin in the same cycle, the pin stays pending.
- R10: Each accepted request gives one response on the next cycle. A response held by low `rsp_ready` keeps `rsp_valid` and `rsp_rdata` stable, and `req_ready` stays low meanwhile.
- R11: A pin marked in only one of the two mode registers behaves as level-triggered.
- R12: After reset, the output, direction, enable, pending and both mode registers are zero, the polarity register is all ones, and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| pad_in | input | NPINS | Asynchronous pad levels |
| pad_out | output | NPINS | Output level per pin |
| pad_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Combined interrupt to the parent controller |

## Verification
The bench makes an acknowledge land in the same cycle as a new rising edge. A design that lets the clear win would lose that event and read the pin as idle. It acknowledges a level pin that is still held active and reads twice, first expecting a cleared bit and then a pending one. A design that never clears would fail the first read, and one that forgets to re-arm would fail the second. It also holds a response with back-pressure while a second request waits, which catches a port that drops or overwrites a held beat. It sets only one of the two mode bits and expects level behaviour, which catches a decoder that treats either bit alone as edge mode.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_W  = 32;
  localparam int NUM_REGS = 12;

  // word index of each register (byte offset = index * 4)
  typedef enum logic [3:0] {
    RG_LEVEL   = 4'd0,
    RG_OUT     = 4'd1,
    RG_OUT_SET = 4'd2,
    RG_OUT_CLR = 4'd3,
    RG_DIR     = 4'd4,
    RG_IEN     = 4'd5,
    RG_IEN_SET = 4'd6,
    RG_IEN_CLR = 4'd7,
    RG_PEND    = 4'd8,
    RG_MODE_A  = 4'd9,
    RG_MODE_B  = 4'd10,
    RG_POL     = 4'd11
  } reg_sel_e;

  typedef struct packed {
    logic out_set;
    logic out_clr;
    logic dir;
    logic ien_set;
    logic ien_clr;
    logic pend_clr;
    logic mode_a;
    logic mode_b;
    logic pol;
  } wr_strobe_t;
endpackage

// File: rtl/gpio_reg_port.sv
module gpio_reg_port
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [REG_W-1:0]  rsp_rdata,
  output wr_strobe_t        wr_stb,
  output logic [REG_W-1:0]  wr_data,
  output reg_sel_e          rd_sel,
  input  logic [REG_W-1:0]  rd_value
);
  localparam int IW = ADDR_W - 2;

  logic          acc;
  logic [IW-1:0] widx;
  logic          sel_ok;

  assign req_ready = ~rsp_valid | rsp_ready;
  assign acc       = req_valid & req_ready;
  assign widx      = req_addr[ADDR_W-1:2];
  assign sel_ok    = (req_addr[1:0] == 2'b00) && (32'(widx) < 32'(NUM_REGS));
  assign rd_sel    = reg_sel_e'(widx[3:0]);
  assign wr_data   = req_wdata;

  always_comb begin
    wr_stb = '0;
    if (acc && req_write && sel_ok) begin
      case (rd_sel)
        RG_OUT_SET: wr_stb.out_set  = 1'b1;
        RG_OUT_CLR: wr_stb.out_clr  = 1'b1;
        RG_DIR:     wr_stb.dir      = 1'b1;
        RG_IEN_SET: wr_stb.ien_set  = 1'b1;
        RG_IEN_CLR: wr_stb.ien_clr  = 1'b1;
        RG_PEND:    wr_stb.pend_clr = 1'b1;
        RG_MODE_A:  wr_stb.mode_a   = 1'b1;
        RG_MODE_B:  wr_stb.mode_b   = 1'b1;
        RG_POL:     wr_stb.pol      = 1'b1;
        default:    wr_stb          = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= (!req_write && sel_ok) ? rd_value : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] lvl,
  output logic [NPINS-1:0] prev
);
  logic [NPINS-1:0] meta;

  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[i] <= 1'b0;
        lvl[i]  <= 1'b0;
        prev[i] <= 1'b0;
      end else begin
        meta[i] <= pad_in[i];
        lvl[i]  <= meta[i];
        prev[i] <= lvl[i];
      end
    end
  end
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_strobe_t       wr_stb,
  input  logic [NPINS-1:0] wr_data,
  output logic [NPINS-1:0] out_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] ien_q,
  output logic [NPINS-1:0] mode_a_q,
  output logic [NPINS-1:0] mode_b_q,
  output logic [NPINS-1:0] pol_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      dir_q    <= '0;
      ien_q    <= '0;
      mode_a_q <= '0;
      mode_b_q <= '0;
      pol_q    <= '1;
    end else begin
      if (wr_stb.out_set) out_q    <= out_q | wr_data;
      if (wr_stb.out_clr) out_q    <= out_q & ~wr_data;
      if (wr_stb.dir)     dir_q    <= wr_data;
      if (wr_stb.ien_set) ien_q    <= ien_q | wr_data;
      if (wr_stb.ien_clr) ien_q    <= ien_q & ~wr_data;
      if (wr_stb.mode_a)  mode_a_q <= wr_data;
      if (wr_stb.mode_b)  mode_b_q <= wr_data;
      if (wr_stb.pol)     pol_q    <= wr_data;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] prev,
  input  logic [NPINS-1:0] mode_a,
  input  logic [NPINS-1:0] mode_b,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] pend_q,
  output logic [NPINS-1:0] pend_ev,
  output logic [NPINS-1:0] edge_sel
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic is_edge;
    logic hit;

    always_comb begin
      is_edge = mode_a[i] & mode_b[i];
      if (is_edge)
        hit = pol[i] ? (lvl[i] & ~prev[i]) : (~lvl[i] & prev[i]);
      else
        hit = (lvl[i] == pol[i]);
    end

    assign pend_ev[i]  = hit;
    assign edge_sel[i] = is_edge;

    // edge pins: a fresh event beats a clear; level pins: a clear wins
    // for one cycle and the held level re-arms the bit afterwards
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend_q[i] <= 1'b0;
      else if (is_edge)
        pend_q[i] <= (pend_q[i] & ~clr[i]) | hit;
      else
        pend_q[i] <= clr[i] ? 1'b0 : (pend_q[i] | hit);
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);
  wr_strobe_t       wr_stb;
  logic [REG_W-1:0] wr_data;
  reg_sel_e         rd_sel;
  logic [REG_W-1:0] rd_value;

  logic [NPINS-1:0] sync_lvl, sync_prev;
  logic [NPINS-1:0] out_q, dir_q, ien_q, mode_a_q, mode_b_q, pol_q;
  logic [NPINS-1:0] pend_q, pend_ev, edge_sel, pend_clr;

  gpio_reg_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_sel(rd_sel), .rd_value(rd_value)
  );

  gpio_pad_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .lvl(sync_lvl), .prev(sync_prev)
  );

  gpio_ctrl_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data[NPINS-1:0]),
    .out_q(out_q), .dir_q(dir_q), .ien_q(ien_q),
    .mode_a_q(mode_a_q), .mode_b_q(mode_b_q), .pol_q(pol_q)
  );

  assign pend_clr = wr_stb.pend_clr ? wr_data[NPINS-1:0] : '0;

  gpio_irq_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .lvl(sync_lvl), .prev(sync_prev),
    .mode_a(mode_a_q), .mode_b(mode_b_q), .pol(pol_q), .clr(pend_clr),
    .pend_q(pend_q), .pend_ev(pend_ev), .edge_sel(edge_sel)
  );

  always_comb begin
    case (rd_sel)
      RG_LEVEL:  rd_value = REG_W'(sync_lvl);
      RG_OUT:    rd_value = REG_W'(out_q);
      RG_DIR:    rd_value = REG_W'(dir_q);
      RG_IEN:    rd_value = REG_W'(ien_q);
      RG_PEND:   rd_value = REG_W'(pend_q);
      RG_MODE_A: rd_value = REG_W'(mode_a_q);
      RG_MODE_B: rd_value = REG_W'(mode_b_q);
      RG_POL:    rd_value = REG_W'(pol_q);
      default:   rd_value = '0;
    endcase
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
  assign irq     = |(pend_q & ien_q);
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  ien_q,
  input logic [NPINS-1:0]  pend_q,
  input logic [NPINS-1:0]  pend_ev,
  input logic [NPINS-1:0]  edge_sel,
  input logic [NPINS-1:0]  pend_clr
);
  localparam int IW = ADDR_W - 2;

  logic          wacc;
  logic [IW-1:0] widx;
  assign wacc = req_valid && req_ready && req_write && (req_addr[1:0] == 2'b00);
  assign widx = req_addr[ADDR_W-1:2];

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_req_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_out_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wacc && widx == IW'(2)) |=>
      ((pad_out & $past(req_wdata[NPINS-1:0])) == $past(req_wdata[NPINS-1:0])));

  assert_out_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wacc && widx == IW'(3)) |=> ((pad_out & $past(req_wdata[NPINS-1:0])) == '0));

  assert_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wacc && widx == IW'(4)) |=> (pad_oe == $past(req_wdata[NPINS-1:0])));

  assert_ien_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wacc && widx == IW'(5)) |=> $stable(ien_q));

  assert_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_clr & ~pend_ev) != '0) |=> ((pend_q & $past(pend_clr & ~pend_ev)) == '0));

  assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_ev & edge_sel) != '0) |=>
      ((pend_q & $past(pend_ev & edge_sel)) == $past(pend_ev & edge_sel)));
endmodule

bind gpio_irq_bank gpio_bank_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .pad_out(pad_out), .pad_oe(pad_oe), .ien_q(ien_q),
  .pend_q(pend_q), .pend_ev(pend_ev), .edge_sel(edge_sel), .pend_clr(pend_clr)
);

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/100ps
module sim_gpio_irq_bank;
  localparam int N  = 32;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_LVL = 8'h00, A_OUT = 8'h04, A_OSET = 8'h08,
    A_OCLR = 8'h0C, A_DIR = 8'h10, A_IEN = 8'h14, A_ISET = 8'h18,
    A_ICLR = 8'h1C, A_PEND = 8'h20, A_MA = 8'h24, A_MB = 8'h28, A_POL = 8'h2C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe;

  always #2.5 clk = ~clk;

  gpio_irq_bank #(.NPINS(N), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  typedef struct { bit chk; logic [31:0] exp; string tag; } exp_t;
  exp_t sb_q[$];
  int checks = 0;
  int fails  = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: a response seen valid and ready here is taken at the next edge
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        e = sb_q.pop_front();
        if (e.chk) check(e.tag, rsp_rdata, e.exp);
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic issue(bit w, logic [AW-1:0] a, logic [31:0] d, bit chk,
                       logic [31:0] exp, string tag);
    exp_t e;
    e.chk = chk; e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) step();
    @(posedge clk);
    step();
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    issue(1'b1, a, d, 1'b0, '0, "wr");
  endtask

  task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
    issue(1'b0, a, '0, 1'b1, exp, tag);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    step();
    // R12 reset state
    check("R12 pad_out", pad_out, '0);
    check("R12 pad_oe", pad_oe, '0);
    check("R12 irq", {31'b0, irq}, 32'h0);
    check("R12 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    rd(A_POL, 32'hFFFF_FFFF, "R12 polarity");
    rd(A_MA, 32'h0, "R12 mode_a");
    rd(A_PEND, 32'h0, "R12 pending");
    rd(A_IEN, 32'h0, "R12 enable");

    // R3 direction
    wr(A_DIR, 32'h0000_F0F0);
    rd(A_DIR, 32'h0000_F0F0, "R3 dir read");
    check("R3 pad_oe", pad_oe, 32'h0000_F0F0);

    // R2 set/clear output
    wr(A_OSET, 32'h0000_00FF);
    check("R2 set", pad_out, 32'h0000_00FF);
    wr(A_OCLR, 32'h0000_000F);
    check("R2 clear", pad_out, 32'h0000_00F0);
    wr(A_OSET, 32'h0);
    rd(A_OUT, 32'h0000_00F0, "R2 zero bits unchanged");

    // R1 level read, R8 masked pending, R5 partial ack
    pad_in = 32'hA5A5_1234;
    idle(4);
    rd(A_LVL, 32'hA5A5_1234, "R1 level");
    rd(A_PEND, 32'hA5A5_1234, "R8 masked pins pending");
    check("R8 irq masked", {31'b0, irq}, 32'h0);
    pad_in = '0;
    idle(4);
    wr(A_PEND, 32'h0000_0234);
    rd(A_PEND, 32'hA5A5_1000, "R5 partial ack");
    wr(A_PEND, 32'hFFFF_FFFF);
    rd(A_PEND, 32'h0, "R5 full ack");

    // R4 enable via set/clear only
    wr(A_IEN, 32'hFFFF_FFFF);
    rd(A_IEN, 32'h0, "R4 direct write ignored");
    wr(A_ISET, 32'h3);
    rd(A_IEN, 32'h3, "R4 set");
    wr(A_ICLR, 32'h1);
    rd(A_IEN, 32'h2, "R4 clear");

    // R7 level re-arm, R8 irq
    pad_in = 32'h2;
    idle(4);
    check("R8 irq enabled level", {31'b0, irq}, 32'h1);
    wr(A_PEND, 32'h2);
    rd(A_PEND, 32'h0, "R7 cleared one cycle");
    rd(A_PEND, 32'h2, "R7 re-armed");
    pad_in = '0;
    idle(4);
    wr(A_PEND, 32'h2);
    rd(A_PEND, 32'h0, "R7 released");
    check("R8 irq low", {31'b0, irq}, 32'h0);

    // R6 edge modes
    wr(A_MA, 32'h30);
    wr(A_MB, 32'h30);
    pad_in = 32'h10;
    idle(4);
    rd(A_PEND, 32'h10, "R6 rising");
    wr(A_PEND, 32'h10);
    rd(A_PEND, 32'h0, "R6 ack");
    rd(A_PEND, 32'h0, "R6 held level no re-arm");
    pad_in = '0;
    idle(4);
    rd(A_PEND, 32'h0, "R6 falling ignored on rising pin");
    wr(A_POL, 32'hFFFF_FFDF);
    pad_in = 32'h20;
    idle(4);
    rd(A_PEND, 32'h0, "R6 rising ignored on falling pin");
    pad_in = '0;
    idle(4);
    rd(A_PEND, 32'h20, "R6 falling");
    wr(A_PEND, 32'h20);

    // R11 one mode bit only -> level
    wr(A_MA, 32'h70);
    pad_in = 32'h40;
    idle(4);
    rd(A_PEND, 32'h40, "R11 pending");
    wr(A_PEND, 32'h40);
    rd(A_PEND, 32'h0, "R11 cleared one cycle");
    rd(A_PEND, 32'h40, "R11 level re-arm");
    pad_in = '0;
    idle(4);
    wr(A_PEND, 32'h40);
    rd(A_PEND, 32'h0, "R11 released");

    // R9 ack coincides with a new rising edge
    pad_in = 32'h10;
    idle(4);
    pad_in = '0;
    idle(4);
    pad_in = 32'h10;
    step();
    step();
    wr(A_PEND, 32'h10);
    rd(A_PEND, 32'h10, "R9 event beats ack");

    // R8 enable gating
    check("R8 pending but masked", {31'b0, irq}, 32'h0);
    wr(A_ISET, 32'h10);
    check("R8 enabled irq", {31'b0, irq}, 32'h1);
    wr(A_PEND, 32'h10);
    check("R8 irq after ack", {31'b0, irq}, 32'h0);

    // R10 back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    step();
    rd(A_DIR, 32'h0000_F0F0, "R10 held read");
    for (int k = 0; k < 3; k++) begin
      check("R10 held valid", {31'b0, rsp_valid}, 32'h1);
      check("R10 req blocked", {31'b0, req_ready}, 32'h0);
      check("R10 held data", rsp_rdata, 32'h0000_F0F0);
      step();
    end
    begin
      exp_t e;
      e.chk = 1'b1; e.exp = 32'h0000_00F0; e.tag = "R10 queued read";
      sb_q.push_back(e);
    end
    req_valid = 1'b1; req_write = 1'b0; req_addr = A_OUT;
    step();
    check("R10 second request waits", {31'b0, req_ready}, 32'h0);
    @(posedge clk); #1 rsp_ready = 1'b1;
    @(posedge clk);
    step();
    req_valid = 1'b0;
    idle(5);
    check("R10 all responses seen", sb_q.size(), 32'h0);

    summary();
    $finish;
  end
endmodule